// File: doc/BRIEF.md
# Free-Running Timer with Power-Mode Behaviour

This block is a 16-bit up-counter that runs freely on a tick enable. It raises an overflow flag each time it wraps through zero and has one input capture channel that can be set to either edge. A byte-wide register bus lets software read the count, the captured value and the flags, and set the interrupt enables and the capture polarity. The single interrupt output is meant for the processor's interrupt controller.

The block follows the processor's power mode, which arrives on `pm_mode`. In wait and halt the timer runs as it does in run mode. In stop the count is frozen. A capture edge seen during stop is held back without raising a flag until stop ends, unless stop ends through an external reset, which loads the count with 0xFFFC and drops the held edge. The overflow flag can be cleared only by a two-access sequence, and no reset touches it.

Top module: `frt_timer`

## Requirements
- R1: With `tick_en` high and `pm_mode` not stop (stop is code 3), the count rises by one per clock and wraps from 0xFFFF to 0x0000. Reading address 0x18 returns its high byte and 0x19 its low byte.
- R2: A wrap from 0xFFFF to 0x0000 sets the overflow flag, which reads as bit 7 of the status register at address 0x13.
- R3: The overflow flag clears only when a read of the status register made while the flag is set is followed later by a read or write of address 0x19. A status read alone, an access to 0x19 alone, or an access to 0x19 after a status read made while the flag was clear leaves the flag set.
- R4: Neither `ext_rst` nor any other reset except power-on `rst_n` changes the overflow flag.
- R5: In wait (code 1) and halt (code 2) the count advances and the overflow flag and interrupt behave exactly as in run (code 0).
- R6: In stop the count holds its value whatever `tick_en` does. After a normal exit from stop it resumes counting from the held value.
- R7: `ext_rst` loads the count with 0xFFFC and clears the control register, the capture flag and the captured data. Power-on `rst_n` gives the same state and also clears the overflow flag.
- R8: The control register at 0x12 holds the overflow interrupt enable in bit 0, the capture interrupt enable in bit 1 and the capture polarity in bit 2 (1 for rising, 0 for falling). After a two-flop synchroniser, an edge of the selected polarity on `cap_pin` latches the count into the capture registers (high byte at 0x14, low byte at 0x15) and sets the capture flag in status bit 6. An edge of the other polarity has no effect.
- R9: While the capture flag is set, a new capture does not overwrite the captured data. A read of address 0x15 clears the capture flag.
- R10: A selected edge during stop sets no flag and does not assert `irq`. On a normal exit from stop, the capture flag is set and the data holds the count at the first such edge.
- R11: An `ext_rst` during stop throws away a capture edge held from that stop, so after exit the capture flag reads 0 and the captured data reads 0.
- R12: `irq` is high exactly when (overflow flag and control bit 0) or (capture flag and control bit 1).
- R13: The control register reads back bits [2:0] with all other bits 0. Unmapped addresses read 0, and writes to addresses other than 0x12 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_en | input | 1 | Count enable, one count per clock while high |
| pm_mode | input | 2 | Power mode: 0 run, 1 wait, 2 halt, 3 stop |
| ext_rst | input | 1 | Synchronous external reset pulse, active high |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd`, 0 otherwise |
| cap_pin | input | 1 | Asynchronous capture input |
| irq | output | 1 | Timer interrupt request |

## Verification
A stuck or mis-set arm bit in the overflow clear sequence appears as the overflow flag surviving, or vanishing on, the first access to 0x19 after a status read, so the bench reads the status register around each step. A held capture that is lost, committed early or kept past an external reset shows in status bit 6 and on `irq` within two clocks of leaving stop. Errors in the count or the freeze show in the next read of 0x18 or 0x19, because the bench runs the count for exact tick windows and compares each byte with the value worked out from the start value.

// File: rtl/frt_pkg.sv
package frt_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_HALT = 2'd2,
        PM_STOP = 2'd3
    } pmode_e;

    localparam int CTL_OVF_IE = 0;
    localparam int CTL_CAP_IE = 1;
    localparam int CTL_EDGE   = 2;
    localparam int CTL_BITS   = 3;

    localparam int STS_OVF = 7;
    localparam int STS_CAP = 6;

endpackage

// File: rtl/frt_sync.sv
module frt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic lvl_prev
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl      = st_q.sh[STAGES-1];
    assign lvl_prev = st_q.prev;

endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int             CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             stop,
    input  logic             ext_rst,
    input  logic             sts_rd,
    input  logic             lo_acc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             arm;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    adv;
    logic    wrap;

    always_comb begin
        adv  = tick_en && !stop && !ext_rst;
        wrap = adv && (st_q.cnt == '1);
        st_d = st_q;
        // first step of the clear: status seen while the flag is up
        if (sts_rd && st_q.ovf) begin
            st_d.arm = 1'b1;
        end
        // second step: low-byte access after an armed status read
        if (lo_acc && st_q.arm) begin
            st_d.ovf = 1'b0;
            st_d.arm = 1'b0;
        end
        if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // a new wrap wins over a clear in the same cycle
        if (wrap) begin
            st_d.ovf = 1'b1;
        end
        if (ext_rst) begin
            st_d.cnt = RST_VAL;
            st_d.arm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= RST_VAL;
            st_q.ovf <= 1'b0;
            st_q.arm <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !stop && !ext_rst) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    assert_wrap_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !stop && !ext_rst && st_q.cnt == '1) |=> st_q.ovf);

    assert_unarmed_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !st_q.arm) |=> st_q.ovf);

    assert_ext_rst_keeps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst && !lo_acc) |=> (st_q.ovf == $past(st_q.ovf)));

    assert_stop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !ext_rst) |=> $stable(st_q.cnt));

    assert_ext_rst_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> (st_q.cnt == RST_VAL));

endmodule

// File: rtl/frt_capture.sv
module frt_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             ext_rst,
    input  logic             rise_sel,
    input  logic             lvl,
    input  logic             lvl_prev,
    input  logic [CNT_W-1:0] cnt,
    input  logic             lo_rd,
    output logic [CNT_W-1:0] cap_data,
    output logic             cap_flag
);

    typedef struct packed {
        logic [CNT_W-1:0] data;
        logic             flag;
        logic             pend;
        logic [CNT_W-1:0] pend_data;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    hit;
    logic    locked;

    always_comb begin
        hit    = rise_sel ? (lvl && !lvl_prev) : (!lvl && lvl_prev);
        locked = st_q.flag && !lo_rd;
        st_d   = st_q;
        if (lo_rd) begin
            st_d.flag = 1'b0;
        end
        if (stop) begin
            // remember only the first edge of this stop, quietly
            if (hit && !st_q.pend) begin
                st_d.pend      = 1'b1;
                st_d.pend_data = cnt;
            end
        end else if (st_q.pend) begin
            st_d.pend = 1'b0;
            st_d.flag = 1'b1;
            if (!locked) begin
                st_d.data = st_q.pend_data;
            end
        end else if (hit) begin
            st_d.flag = 1'b1;
            if (!locked) begin
                st_d.data = cnt;
            end
        end
        if (ext_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_data = st_q.data;
    assign cap_flag = st_q.flag;

    assert_locked_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !lo_rd && !ext_rst) |=> $stable(st_q.data));

    assert_stop_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !$rose(st_q.flag));

    assert_first_edge_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && st_q.pend && !ext_rst) |=> $stable(st_q.pend_data));

    assert_rst_discards_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> (!st_q.pend && !st_q.flag && st_q.data == '0));

endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_pkg::*;
#(
    parameter int                ADDR_W      = 5,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] A_CTL       = 5'h12,
    parameter logic [ADDR_W-1:0] A_STS       = 5'h13,
    parameter logic [ADDR_W-1:0] A_CAP_HI    = 5'h14,
    parameter logic [ADDR_W-1:0] A_CAP_LO    = 5'h15,
    parameter logic [ADDR_W-1:0] A_CNT_HI    = 5'h18,
    parameter logic [ADDR_W-1:0] A_CNT_LO    = 5'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [1:0]        pm_mode,
    input  logic              ext_rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_pin,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'((1 << CTL_BITS) - 1);

    typedef struct packed {
        logic [DATA_W-1:0] ctl;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             stop;
    logic             sts_rd;
    logic             lo_acc;
    logic             cap_lo_rd;
    logic             lvl;
    logic             lvl_prev;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap_data;
    logic             ovf;
    logic             cap_flag;
    logic [DATA_W-1:0] sts_byte;

    assign stop      = (pmode_e'(pm_mode) == PM_STOP);
    assign sts_rd    = bus_rd && (bus_addr == A_STS);
    assign lo_acc    = (bus_rd || bus_wr) && (bus_addr == A_CNT_LO);
    assign cap_lo_rd = bus_rd && (bus_addr == A_CAP_LO);

    frt_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    frt_counter #(
        .CNT_W   (CNT_W),
        .RST_VAL (CNT_W'(16'hFFFC))
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .stop    (stop),
        .ext_rst (ext_rst),
        .sts_rd  (sts_rd),
        .lo_acc  (lo_acc),
        .cnt     (cnt),
        .ovf     (ovf)
    );

    frt_capture #(
        .CNT_W (CNT_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (stop),
        .ext_rst  (ext_rst),
        .rise_sel (st_q.ctl[CTL_EDGE]),
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .cnt      (cnt),
        .lo_rd    (cap_lo_rd),
        .cap_data (cap_data),
        .cap_flag (cap_flag)
    );

    always_comb begin
        st_d = st_q;
        if (bus_wr && (bus_addr == A_CTL)) begin
            st_d.ctl = bus_wdata & CTL_MASK;
        end
        if (ext_rst) begin
            st_d.ctl = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sts_byte          = '0;
        sts_byte[STS_OVF] = ovf;
        sts_byte[STS_CAP] = cap_flag;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTL:    bus_rdata = st_q.ctl;
                A_STS:    bus_rdata = sts_byte;
                A_CAP_HI: bus_rdata = cap_data[CNT_W-1 -: DATA_W];
                A_CAP_LO: bus_rdata = cap_data[DATA_W-1:0];
                A_CNT_HI: bus_rdata = cnt[CNT_W-1 -: DATA_W];
                A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = (ovf && st_q.ctl[CTL_OVF_IE]) || (cap_flag && st_q.ctl[CTL_CAP_IE]);

    assert_irq_has_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf || cap_flag));

    assert_ctl_upper_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl & ~CTL_MASK) == '0);

    assert_ctl_only_by_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rst && !(bus_wr && bus_addr == A_CTL)) |=> $stable(st_q.ctl));

endmodule

// File: tb/frt_timer_tb.sv
module frt_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] pm_mode = 2'd0;
    logic       ext_rst = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    localparam logic [4:0] CTL = 5'h12, STS = 5'h13, CAPH = 5'h14,
                           CAPL = 5'h15, CNTH = 5'h18, CNTL = 5'h19;

    always #4 clk = ~clk;

    frt_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .pm_mode   (pm_mode),
        .ext_rst   (ext_rst),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_pin   (cap_pin),
        .irq       (irq)
    );

    // monitor: pops one expected item for every read cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (bus_rd) begin
                n_checks++;
                if (sbq.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard empty: read 0x%02h got 0x%02h", bus_addr, bus_rdata);
                end else begin
                    exp_t it;
                    it = sbq.pop_front();
                    if (bus_rdata !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: addr 0x%02h actual 0x%02h expected 0x%02h",
                                 it.tag, bus_addr, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = a;
        it.exp   = e;
        it.tag   = tag;
        sbq.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic pulse_ext;
        @(negedge clk);
        ext_rst = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0;
    endtask

    task automatic pin(input logic v);
        @(negedge clk);
        cap_pin = v;
        idle(4);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        #1;
        n_checks++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // power-on state
        chk_irq(1'b0, "R12 reset");
        rd(CTL,  8'h00, "R13 ctl reset");
        rd(STS,  8'h00, "R7 status reset");
        rd(CNTH, 8'hFF, "R7 count hi reset");
        rd(CNTL, 8'hFC, "R7 count lo reset");
        rd(CAPH, 8'h00, "R7 cap hi reset");
        rd(CAPL, 8'h00, "R7 cap lo reset");
        rd(5'h10, 8'h00, "R13 unmapped read");

        // count through the wrap, then the two-step clear
        tick(10);
        rd(CNTL, 8'h06, "R1 count lo after wrap");
        rd(CNTH, 8'h00, "R1 count hi after wrap");
        rd(STS,  8'h80, "R2 flag set, R3 low access alone");
        rd(CTL,  8'h00, "R3 other access");
        rd(STS,  8'h80, "R3 status alone");
        rd(CNTL, 8'h06, "R3 completing access");
        rd(STS,  8'h00, "R3 flag cleared");

        wr(CTL, 8'h01);
        wr(5'h0A, 8'hFF);
        rd(CTL, 8'h01, "R13 write elsewhere ignored");
        chk_irq(1'b0, "R12 enabled, no flag");

        // status read with the flag clear does not arm
        rd(STS, 8'h00, "R3 status while clear");
        pulse_ext();
        rd(CTL, 8'h00, "R7 ctl cleared by ext reset");
        tick(4);
        rd(CNTL, 8'h00, "R1 wrap to zero");
        rd(STS,  8'h80, "R3 unarmed low access keeps flag");
        pulse_ext();
        rd(STS,  8'h80, "R4 ext reset keeps flag");
        rd(CNTH, 8'hFF, "R7 count reloaded");
        wr(CTL, 8'hF9);
        rd(CTL, 8'h01, "R13 upper ctl bits read 0");
        chk_irq(1'b1, "R12 overflow irq");
        rd(CNTL, 8'hFC, "R3 armed clear access");
        chk_irq(1'b0, "R12 irq drops with flag");

        // wait and halt keep counting
        pm_mode = 2'd1;
        tick(3);
        rd(CNTL, 8'hFF, "R5 counting in wait");
        pm_mode = 2'd2;
        tick(1);
        rd(CNTL, 8'h00, "R5 wrap in halt");
        rd(STS,  8'h80, "R5 flag in halt");
        chk_irq(1'b1, "R5 irq in halt");
        pm_mode = 2'd0;
        rd(CNTL, 8'h00, "R3 clear after halt");
        rd(STS,  8'h00, "R3 cleared after halt");

        // stop freezes the count
        pm_mode = 2'd3;
        tick(5);
        rd(CNTL, 8'h00, "R6 count held lo");
        rd(CNTH, 8'h00, "R6 count held hi");
        pm_mode = 2'd0;
        tick(2);
        rd(CNTL, 8'h02, "R6 resume from held");

        // rising capture, then no overwrite while unread
        wr(CTL, 8'h06);
        rd(CTL, 8'h06, "R8 ctl readback");
        pin(1'b1);
        rd(STS, 8'h40, "R8 capture flag");
        chk_irq(1'b1, "R12 capture irq");
        tick(3);
        pin(1'b0);
        pin(1'b1);
        rd(CAPH, 8'h00, "R9 cap hi kept");
        rd(STS,  8'h40, "R9 flag still set");
        rd(CAPL, 8'h02, "R9 first data kept");
        rd(STS,  8'h00, "R9 read clears flag");
        chk_irq(1'b0, "R12 capture irq drops");

        // polarity selection
        pin(1'b0);
        rd(STS, 8'h00, "R8 falling ignored when rising set");
        wr(CTL, 8'h02);
        tick(1);
        pin(1'b1);
        rd(STS, 8'h00, "R8 rising ignored when falling set");
        pin(1'b0);
        rd(STS,  8'h40, "R8 falling captured");
        rd(CAPL, 8'h06, "R8 falling data");

        // edge held during stop, shown on a normal exit
        tick(4);
        pm_mode = 2'd3;
        tick(2);
        pin(1'b1);
        pin(1'b0);
        tick(2);
        rd(STS, 8'h00, "R10 no flag in stop");
        chk_irq(1'b0, "R10 no irq in stop");
        @(negedge clk);
        pm_mode = 2'd0;
        idle(2);
        rd(STS,  8'h40, "R10 flag after wake");
        chk_irq(1'b1, "R10 irq after wake");
        rd(CAPH, 8'h00, "R10 data hi");
        rd(CAPL, 8'h0A, "R10 data from stop edge");

        // edge held during stop, dropped by ext reset
        pm_mode = 2'd3;
        pin(1'b1);
        pin(1'b0);
        pulse_ext();
        @(negedge clk);
        pm_mode = 2'd0;
        idle(2);
        rd(STS,  8'h00, "R11 no flag after reset exit");
        rd(CAPL, 8'h00, "R11 no data lo");
        rd(CAPH, 8'h00, "R11 no data hi");
        rd(CNTH, 8'hFF, "R7 count hi after reset exit");
        rd(CNTL, 8'hFC, "R7 count lo after reset exit");
        chk_irq(1'b0, "R12 idle after reset exit");

        idle(3);
        done = 1'b1;
        finish_run();
    end

endmodule